// File: doc/BRIEF.md
# Barrel Shifter With Carry Out

This block shifts one register operand by a variable amount and reports the bit that falls off the end, the way a processor datapath needs it both for stand-alone shift instructions and for a shifted second operand feeding an ALU. Five operations are offered: logical left, logical right, arithmetic right, rotate right, and a one-place rotate right through the incoming carry flag. The operand is never modified; only the shifted copy leaves the block.

Alongside the result the block drives the new carry value and a write-enable for the carry flag. A zero amount passes the operand through and leaves the flag alone. An amount that the selected operation does not permit, or an unassigned operation code, raises a flag and also leaves operand and carry untouched, so the consumer can trap without special muxing. A parameter selects whether the outputs are registered (one cycle of latency) or purely combinational.

Top module: `barrel_shift_carry`

## Requirements
- R1: Operation code 0 (shift left) with amount n in 1..W-1 gives the operand moved up n places with zeros entering at bit 0, and carry-out equal to operand bit W-n.
- R2: Operation code 1 (logical right) with n in 1..W gives the operand moved down n places with zeros entering at the top and carry-out equal to operand bit n-1; n = W gives an all-zero result with carry equal to bit W-1.
- R3: Operation code 2 (arithmetic right) with n in 1..W fills the top n bits with the original bit W-1 and carries out bit n-1; n = W gives every bit equal to bit W-1, with that same bit as carry.
- R4: Operation code 3 (rotate right) with n in 1..W-1 moves bit i+n to bit i modulo W and carries out bit n-1.
- R5: Operation code 4 (rotate through carry) ignores the amount input, returns {carry_in, operand[W-1:1]} and carries out operand bit 0.
- R6: For codes 0 to 3 an amount of 0 returns the operand unchanged, repeats carry_in on carry_out and holds the carry write-enable low.
- R7: The carry write-enable is high for every legal non-zero shift of codes 0 to 3 and for every code 4 operation.
- R8: Amount W with code 0 or 3, any amount above W with codes 0 to 3, and codes 5 to 7 raise the illegal flag, return the operand unchanged, repeat carry_in and hold the write-enable low; in every other case the illegal flag is low.
- R9: With the output register enabled (the default), all outputs follow the inputs of the previous clock edge and are zero while reset is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_value | input | 32 | Operand to be shifted |
| op_kind | input | 3 | Operation code: 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry |
| op_amount | input | 6 | Shift distance, 0 to 63 |
| carry_in | input | 1 | Current carry flag |
| sh_result | output | 32 | Shifted operand |
| carry_out | output | 1 | New carry value |
| carry_we | output | 1 | High when the carry flag is to be written |
| bad_amount | output | 1 | Illegal amount or operation code |

## Verification
The assertions watch the unregistered datapath on every cycle for properties that hold regardless of the operand: zeros entering at bit 0 on a left shift, the sign bit surviving an arithmetic shift, bit count preserved by a rotate, the carry feeding the top of a rotate-through-carry, pass-through on a zero amount, and the write-enable never rising together with the illegal flag. Exact bit placement and carry selection for every distance, the boundary distances W-1 and W, the illegal cases and the register latency and reset value are only shown by the bench, which compares every output word against a bit-by-bit reference over directed corner vectors and a long pseudo-random sweep.

// File: rtl/shift_pkg.sv
package shift_pkg;

   typedef enum logic [2:0] {
      SK_LSL = 3'd0,
      SK_LSR = 3'd1,
      SK_ASR = 3'd2,
      SK_ROR = 3'd3,
      SK_RRX = 3'd4
   } shift_kind_e;

   localparam int unsigned KIND_W = 3;

endpackage

// File: rtl/shift_legal_check.sv
module shift_legal_check
   import shift_pkg::*;
#(
   parameter int unsigned W     = 32,
   parameter int unsigned AMT_W = $clog2(W + 1)
) (
   input  logic [KIND_W-1:0] kind,
   input  logic [AMT_W-1:0]  amount,
   output logic              bad
);

   localparam logic [AMT_W-1:0] AMT_MAX = AMT_W'(W);

   always_comb begin
      bad = 1'b0;
      unique case (kind)
         SK_LSL, SK_ROR: bad = (amount >= AMT_MAX);
         SK_LSR, SK_ASR: bad = (amount >  AMT_MAX);
         SK_RRX:         bad = 1'b0;
         default:        bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/shift_core.sv
module shift_core
   import shift_pkg::*;
#(
   parameter int unsigned W     = 32,
   parameter int unsigned AMT_W = $clog2(W + 1)
) (
   input  logic [W-1:0]      value,
   input  logic [KIND_W-1:0] kind,
   input  logic [AMT_W-1:0]  amount,
   input  logic              cin,
   input  logic              bad,
   output logic [W-1:0]      res,
   output logic              cy,
   output logic              we
);

   localparam int unsigned RW = W + 1;

   logic [W-1:0] fill;
   logic [W:0]   left_w;
   logic [W:0]   right_w;

   // fill word selects the right-shift variant
   always_comb begin
      unique case (kind)
         SK_ASR:  fill = {W{value[W-1]}};
         SK_ROR:  fill = value;
         default: fill = '0;
      endcase
   end

   // left: carry lands one place above the result word
   assign left_w  = {1'b0, value} << amount;
   // right: a guard bit below bit 0 catches the carry
   assign right_w = RW'({fill, value, 1'b0} >> amount);

   always_comb begin
      res = value;
      cy  = cin;
      we  = 1'b0;
      if (!bad) begin
         if (kind == SK_RRX) begin
            res = {cin, value[W-1:1]};
            cy  = value[0];
            we  = 1'b1;
         end else if (amount != '0) begin
            we = 1'b1;
            if (kind == SK_LSL) begin
               res = left_w[W-1:0];
               cy  = left_w[W];
            end else begin
               res = right_w[W:1];
               cy  = right_w[0];
            end
         end
      end
   end

endmodule

// File: rtl/barrel_shift_carry.sv
module barrel_shift_carry
   import shift_pkg::*;
#(
   parameter int unsigned W       = 32,
   parameter bit          REG_OUT = 1'b1,
   parameter int unsigned AMT_W   = $clog2(W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      op_value,
   input  logic [KIND_W-1:0] op_kind,
   input  logic [AMT_W-1:0]  op_amount,
   input  logic              carry_in,
   output logic [W-1:0]      sh_result,
   output logic              carry_out,
   output logic              carry_we,
   output logic              bad_amount
);

   if (W < 2) begin : g_w_check
      $error("barrel_shift_carry: W must be at least 2");
   end
   if ((1 << AMT_W) <= W) begin : g_amt_check
      $error("barrel_shift_carry: AMT_W too narrow to hold W");
   end

   logic [W-1:0] c_res;
   logic         c_cy;
   logic         c_we;
   logic         c_bad;

   shift_legal_check #(.W(W), .AMT_W(AMT_W)) i_legal (
      .kind   (op_kind),
      .amount (op_amount),
      .bad    (c_bad)
   );

   shift_core #(.W(W), .AMT_W(AMT_W)) i_core (
      .value  (op_value),
      .kind   (op_kind),
      .amount (op_amount),
      .cin    (carry_in),
      .bad    (c_bad),
      .res    (c_res),
      .cy     (c_cy),
      .we     (c_we)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh_result  <= '0;
            carry_out  <= 1'b0;
            carry_we   <= 1'b0;
            bad_amount <= 1'b0;
         end else begin
            sh_result  <= c_res;
            carry_out  <= c_cy;
            carry_we   <= c_we;
            bad_amount <= c_bad;
         end
      end
   end else begin : g_comb
      assign sh_result  = c_res;
      assign carry_out  = c_cy;
      assign carry_we   = c_we;
      assign bad_amount = c_bad;
   end

   // ---------------- assertions ----------------
   assert_lsl_zero_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind == SK_LSL && !c_bad && op_amount != '0) |-> (c_res[0] == 1'b0));

   assert_asr_sign_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind == SK_ASR && !c_bad) |-> (c_res[W-1] == op_value[W-1]));

   assert_ror_popcount_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind == SK_ROR && !c_bad) |-> ($countones(c_res) == $countones(op_value)));

   assert_rrx_carry_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind == SK_RRX) |-> (c_res[W-1] == carry_in && c_cy == op_value[0] && c_we));

   assert_zero_amount_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_amount == '0 && op_kind < SK_RRX) |-> (c_res == op_value && c_cy == carry_in && !c_we));

   assert_bad_blocks_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      c_bad |-> (!c_we && c_res == op_value && c_cy == carry_in));

endmodule

// File: tb/test_barrel_shift_carry.sv
module test_barrel_shift_carry;

   localparam int W = 32;

   typedef struct {
      logic [W-1:0] res;
      logic         cy;
      logic         we;
      logic         bad;
      string        tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_value = '0;
   logic [2:0]  op_kind = '0;
   logic [5:0]  op_amount = '0;
   logic        carry_in = 1'b0;
   logic [31:0] sh_result;
   logic        carry_out;
   logic        carry_we;
   logic        bad_amount;

   int   n_checks = 0;
   int   n_fail   = 0;
   bit   finished = 1'b0;
   exp_t sb_q[$];

   always #10 clk = ~clk;

   barrel_shift_carry i_barrel_shift_carry (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_value   (op_value),
      .op_kind    (op_kind),
      .op_amount  (op_amount),
      .carry_in   (carry_in),
      .sh_result  (sh_result),
      .carry_out  (carry_out),
      .carry_we   (carry_we),
      .bad_amount (bad_amount)
   );

   // bit-by-bit reference model
   function automatic exp_t model(logic [31:0] v, logic [2:0] k, int n, logic c);
      exp_t e;
      e.res = v; e.cy = c; e.we = 1'b0; e.bad = 1'b0;
      if (k > 3'd4 || (k != 3'd4 && (n > W || ((k == 3'd0 || k == 3'd3) && n == W)))) begin
         e.bad = 1'b1; e.tag = "R8";
      end else if (k == 3'd4) begin
         e.res = {c, v[31:1]}; e.cy = v[0]; e.we = 1'b1; e.tag = "R5";
      end else if (n == 0) begin
         e.tag = "R6";
      end else begin
         e.we = 1'b1;
         for (int i = 0; i < W; i++) begin
            case (k)
               3'd0: e.res[i] = (i - n >= 0) ? v[i-n] : 1'b0;
               3'd1: e.res[i] = (i + n < W) ? v[i+n] : 1'b0;
               3'd2: e.res[i] = (i + n < W) ? v[i+n] : v[W-1];
               default: e.res[i] = v[(i+n) % W];
            endcase
         end
         e.cy = (k == 3'd0) ? v[W-n] : v[n-1];
         case (k)
            3'd0: e.tag = "R1/R7";
            3'd1: e.tag = "R2/R7";
            3'd2: e.tag = "R3/R7";
            default: e.tag = "R4/R7";
         endcase
      end
      return e;
   endfunction

   task automatic drive(logic [31:0] v, logic [2:0] k, int n, logic c);
      @(negedge clk);
      op_value  = v;
      op_kind   = k;
      op_amount = 6'(n);
      carry_in  = c;
      sb_q.push_back(model(v, k, n, c));
   endtask

   // monitor: registered output (R9) appears after the next rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (sh_result !== e.res || carry_out !== e.cy || carry_we !== e.we || bad_amount !== e.bad) begin
               n_fail++;
               $display("FAIL %s/R9: got res=%h cy=%b we=%b bad=%b, expected res=%h cy=%b we=%b bad=%b",
                        e.tag, sh_result, carry_out, carry_we, bad_amount, e.res, e.cy, e.we, e.bad);
            end
         end
      end
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got no completion, expected run to finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      n_checks++;
      if (sh_result !== '0 || carry_out !== 1'b0 || carry_we !== 1'b0 || bad_amount !== 1'b0) begin
         n_fail++;
         $display("FAIL R9 reset: got res=%h cy=%b we=%b bad=%b, expected all zero",
                  sh_result, carry_out, carry_we, bad_amount);
      end
      @(negedge clk);
      rst_n = 1'b1;

      drive(32'h8000_0001, 3'd0, 1, 1'b0);    // R1 smallest left
      drive(32'h0000_0003, 3'd0, 31, 1'b0);   // R1 largest left, carry bit 1
      drive(32'h0000_0002, 3'd0, 31, 1'b1);   // R1 carry = bit 1 = 1
      drive(32'hF000_000F, 3'd1, 4, 1'b0);    // R2
      drive(32'h8000_0000, 3'd1, 32, 1'b0);   // R2 full width
      drive(32'h8000_1234, 3'd2, 5, 1'b0);    // R3 negative
      drive(32'h8000_0000, 3'd2, 32, 1'b0);   // R3 full width negative
      drive(32'h7FFF_FFFF, 3'd2, 32, 1'b1);   // R3 full width positive
      drive(32'h1234_5678, 3'd3, 8, 1'b0);    // R4
      drive(32'h8000_0000, 3'd3, 31, 1'b0);   // R4 boundary
      drive(32'h0000_0001, 3'd4, 0, 1'b1);    // R5
      drive(32'hFFFF_FFFE, 3'd4, 17, 1'b0);   // R5 amount ignored
      drive(32'hDEAD_BEEF, 3'd0, 0, 1'b1);    // R6
      drive(32'hDEAD_BEEF, 3'd2, 0, 1'b0);    // R6
      drive(32'hDEAD_BEEF, 3'd3, 0, 1'b1);    // R6
      drive(32'hCAFE_F00D, 3'd0, 32, 1'b1);   // R8 left by W
      drive(32'hCAFE_F00D, 3'd3, 32, 1'b0);   // R8 rotate by W
      drive(32'hCAFE_F00D, 3'd1, 40, 1'b1);   // R8 over range
      drive(32'hCAFE_F00D, 3'd6, 3, 1'b0);    // R8 unknown code
      drive(32'hCAFE_F00D, 3'd7, 0, 1'b1);    // R8 unknown code

      for (int t = 0; t < 2000; t++) begin
         drive($urandom, 3'($urandom_range(0, 5)), int'($urandom_range(0, 34)), 1'($urandom));
      end

      repeat (3) @(posedge clk);
      #2;
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule